// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block performs the control-state updates a processor core needs when it takes an exception and when it comes back from one. A request is either an entry or a return. With each request the core supplies its current status word, its program counter and a vector of pending exception sources. For an entry, the block chooses the highest-priority eligible source. It then banks the old status word and a return link for the target mode, and reports four values: the rewritten status word, the saved copy, the link and the vector address. For a return, it restores the status word and the program counter from the bank that belongs to the mode currently held in the status word.

Status word layout: the mode field is bits [4:0]. Bit 5 is the compact-instruction state flag (T). Bit 6 masks fast interrupts (F). Bit 7 masks normal interrupts (I). The upper bits are condition flags and are carried through unchanged. Mode encodings are: user 0x10, fast interrupt 0x11, normal interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. The block serves one request per valid/ready handshake, and each request runs as a single indivisible sequence. A high-vector input moves the vector table base. Flushing the pipeline and fetching from the vector address are left to the core.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, req_ready_o is 1, done_o is 0 and all result outputs are 0.
- R2: An entry selects the lowest set bit of the eligible pending vector. The bit order is reset (bit 0), data abort (1), fast interrupt (2), normal interrupt (3), prefetch abort (4), undefined (5), software interrupt (6).
- R3: A pending normal interrupt (bit 3) is not eligible while status bit 7 is set. A pending fast interrupt (bit 2) is not eligible while status bit 6 is set.
- R4: An entry reports code_o and sets pc_o to base + 4*code_o. The codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. The base is 0x00000000, or 0xFFFF0000 when hivec_i is 1.
- R5: The target mode is supervisor for reset and software interrupt, abort for both aborts, fast interrupt mode for the fast interrupt, normal interrupt mode for the normal interrupt, and undefined mode for undefined.
- R6: The entry status_o equals status_i with the following changes: the mode field holds the target mode, bit 5 is cleared and bit 7 is set. Bit 6 is also set for reset and fast interrupt and is unchanged otherwise. All other bits are unchanged.
- R7: On entry, saved_o equals the unmodified status_i and link_o equals pc_i + 4. Both values are stored in the target mode's bank.
- R8: A return whose status_i is in a banked mode with bit 5 clear reports taken_o=1 and is_ret_o=1. It sets status_o to that bank's stored status and pc_o to its stored link.
- R9: A return with bit 5 set, or from user, system or any other unbanked mode, reports taken_o=0. It passes status_o=status_i and pc_o=pc_i through and changes no bank.
- R10: An entry with no eligible source reports taken_o=0 with status_o=status_i and pc_o=pc_i, and changes no bank. On every result other than a taken entry, saved_o, link_o and code_o are 0.
- R11: All inputs are sampled at the accepting edge. req_ready_o is low the cycle after acceptance. done_o is a one-cycle pulse exactly two edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| req_ret_i | input | 1 | 1 = return, 0 = entry |
| pend_i | input | 7 | Pending sources, bit order as in R2 |
| status_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| hivec_i | input | 1 | Select high vector base |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Entry or return carried out |
| is_ret_o | output | 1 | Result belongs to a return request |
| code_o | output | 3 | Selected exception code |
| status_o | output | XLEN | New status word |
| pc_o | output | XLEN | Vector address or restored program counter |
| saved_o | output | XLEN | Status copy written to the bank |
| link_o | output | XLEN | Return link written to the bank |

## Verification
Entries are driven with several pending sources at once. Sources are removed one at a time so that each priority rank wins in turn, which shows whether the arbiter order is right. Both interrupts are pending while masks are set, which separates masking from priority. A request with only masked sources shows the empty case. Condition flags and the F bit are preset in the status word, which shows whether the rewrite touches only the intended bits. The vector base is toggled between requests. Returns follow entries into two different modes, so the restored values show whether the bank was chosen by mode. Returns with the T bit set and from user mode are also tried; these must be refused.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int MODE_W = 5;
  localparam int STAT_T = 5;
  localparam int STAT_F = 6;
  localparam int STAT_I = 7;
  localparam int NSRC   = 7;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);

  localparam logic [MODE_W-1:0] MD_USR = 5'h10;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

  localparam logic [2:0] EX_RST  = 3'd0;
  localparam logic [2:0] EX_UND  = 3'd1;
  localparam logic [2:0] EX_SWI  = 3'd2;
  localparam logic [2:0] EX_PABT = 3'd3;
  localparam logic [2:0] EX_DABT = 3'd4;
  localparam logic [2:0] EX_IRQ  = 3'd6;
  localparam logic [2:0] EX_FIQ  = 3'd7;

  // pending bit position equals priority rank, 0 is highest
  localparam int P_RST  = 0;
  localparam int P_DABT = 1;
  localparam int P_FIQ  = 2;
  localparam int P_IRQ  = 3;
  localparam int P_PABT = 4;
  localparam int P_UND  = 5;
  localparam int P_SWI  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_DONE} seq_state_e;

  typedef struct packed {
    logic              ok;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic logic [2:0] code_of(input int src);
    case (src)
      P_RST:   return EX_RST;
      P_DABT:  return EX_DABT;
      P_FIQ:   return EX_FIQ;
      P_IRQ:   return EX_IRQ;
      P_PABT:  return EX_PABT;
      P_UND:   return EX_UND;
      default: return EX_SWI;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] target_mode(input logic [2:0] code);
    case (code)
      EX_FIQ:           return MD_FIQ;
      EX_IRQ:           return MD_IRQ;
      EX_PABT, EX_DABT: return MD_ABT;
      EX_UND:           return MD_UND;
      default:          return MD_SVC;
    endcase
  endfunction

  function automatic bank_sel_t bank_of(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s.ok = 1'b1;
    case (m)
      MD_FIQ:  s.idx = BANK_W'(0);
      MD_IRQ:  s.idx = BANK_W'(1);
      MD_SVC:  s.idx = BANK_W'(2);
      MD_ABT:  s.idx = BANK_W'(3);
      MD_UND:  s.idx = BANK_W'(4);
      default: begin s.ok = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic            mask_irq_i,
  input  logic            mask_fiq_i,
  output logic            any_o,
  output logic [2:0]      code_o
);
  logic [NSRC-1:0] elig;

  always_comb begin
    elig         = pend_i;
    elig[P_IRQ]  = pend_i[P_IRQ] & ~mask_irq_i;
    elig[P_FIQ]  = pend_i[P_FIQ] & ~mask_fiq_i;
  end

  // scan from lowest rank so the highest eligible source wins last
  always_comb begin
    any_o  = 1'b0;
    code_o = EX_RST;
    for (int k = NSRC-1; k >= 0; k--) begin
      if (elig[k]) begin
        any_o  = 1'b1;
        code_o = code_of(k);
      end
    end
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [2:0]      code_i,
  input  logic            hivec_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] vec_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] link_o,
  output bank_sel_t       bank_o
);
  localparam logic [XLEN-1:0] LINK_ADJ = XLEN'(4);
  localparam int              VEC_SH   = 2;

  logic [MODE_W-1:0] mode;
  logic [XLEN-1:0]   base;

  assign mode   = target_mode(code_i);
  assign base   = hivec_i ? HI_BASE : '0;
  assign vec_o  = base | (XLEN'(code_i) << VEC_SH);
  assign link_o = pc_i + LINK_ADJ;
  assign bank_o = bank_of(mode);

  always_comb begin
    status_o               = status_i;
    status_o[MODE_W-1:0]   = mode;
    status_o[STAT_T]       = 1'b0;
    status_o[STAT_I]       = 1'b1;
    if (code_i == EX_FIQ || code_i == EX_RST) status_o[STAT_F] = 1'b1;
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] widx_i,
  input  logic [XLEN-1:0]   wstat_i,
  input  logic [XLEN-1:0]   wlink_i,
  input  logic [BANK_W-1:0] ridx_i,
  output logic [XLEN-1:0]   rstat_o,
  output logic [XLEN-1:0]   rlink_o
);
  logic [XLEN-1:0] stat_a [NBANK];
  logic [XLEN-1:0] link_a [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [XLEN-1:0] stat_q;
    logic [XLEN-1:0] link_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q <= '0;
        link_q <= '0;
      end else if (we_i && widx_i == BANK_W'(b)) begin
        stat_q <= wstat_i;
        link_q <= wlink_i;
      end
    end
    assign stat_a[b] = stat_q;
    assign link_a[b] = link_q;
  end

  always_comb begin
    rstat_o = '0;
    rlink_o = '0;
    if (ridx_i < BANK_W'(NBANK)) begin
      rstat_o = stat_a[ridx_i];
      rlink_o = link_a[ridx_i];
    end
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_ret_i,
  input  logic [NSRC-1:0] pend_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            hivec_i,
  output logic            done_o,
  output logic            taken_o,
  output logic            is_ret_o,
  output logic [2:0]      code_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] saved_o,
  output logic [XLEN-1:0] link_o
);
  seq_state_e state_q;

  logic            ret_q;
  logic            hivec_q;
  logic [NSRC-1:0] pend_q;
  logic [XLEN-1:0] status_q;
  logic [XLEN-1:0] pc_q;

  logic            any;
  logic [2:0]      code;
  logic [XLEN-1:0] vec;
  logic [XLEN-1:0] ent_status;
  logic [XLEN-1:0] ent_link;
  bank_sel_t       ent_bank;
  bank_sel_t       ret_bank;
  logic            ret_ok;
  logic            bank_we;
  logic [XLEN-1:0] bank_stat;
  logic [XLEN-1:0] bank_link;

  assign req_ready_o = (state_q == ST_IDLE);

  trap_arbiter u_arb (
    .pend_i     (pend_q),
    .mask_irq_i (status_q[STAT_I]),
    .mask_fiq_i (status_q[STAT_F]),
    .any_o      (any),
    .code_o     (code)
  );

  trap_entry #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_ent (
    .code_i   (code),
    .hivec_i  (hivec_q),
    .status_i (status_q),
    .pc_i     (pc_q),
    .vec_o    (vec),
    .status_o (ent_status),
    .link_o   (ent_link),
    .bank_o   (ent_bank)
  );

  assign ret_bank = bank_of(status_q[MODE_W-1:0]);
  assign ret_ok   = ret_bank.ok & ~status_q[STAT_T];
  assign bank_we  = (state_q == ST_EXEC) & ~ret_q & any & ent_bank.ok;

  trap_bank #(.XLEN(XLEN)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .widx_i  (ent_bank.idx),
    .wstat_i (status_q),
    .wlink_i (ent_link),
    .ridx_i  (ret_bank.idx),
    .rstat_o (bank_stat),
    .rlink_o (bank_link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ret_q    <= 1'b0;
      hivec_q  <= 1'b0;
      pend_q   <= '0;
      status_q <= '0;
      pc_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q  <= ST_EXEC;
          ret_q    <= req_ret_i;
          hivec_q  <= hivec_i;
          pend_q   <= pend_i;
          status_q <= status_i;
          pc_q     <= pc_i;
        end
        ST_EXEC: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      taken_o  <= 1'b0;
      is_ret_o <= 1'b0;
      code_o   <= '0;
      status_o <= '0;
      pc_o     <= '0;
      saved_o  <= '0;
      link_o   <= '0;
    end else if (state_q == ST_EXEC) begin
      done_o   <= 1'b1;
      is_ret_o <= ret_q;
      code_o   <= '0;
      saved_o  <= '0;
      link_o   <= '0;
      taken_o  <= 1'b0;
      status_o <= status_q;
      pc_o     <= pc_q;
      if (ret_q) begin
        if (ret_ok) begin
          taken_o  <= 1'b1;
          status_o <= bank_stat;
          pc_o     <= bank_link;
        end
      end else if (any) begin
        taken_o  <= 1'b1;
        code_o   <= code;
        status_o <= ent_status;
        pc_o     <= vec;
        saved_o  <= status_q;
        link_o   <= ent_link;
      end
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [XLEN-1:0] status_i,
  input logic [XLEN-1:0] pc_i,
  input logic            hivec_i,
  input logic            done_o,
  input logic            taken_o,
  input logic            is_ret_o,
  input logic [2:0]      code_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] saved_o,
  input logic [XLEN-1:0] link_o
);
  logic ent_done;
  assign ent_done = done_o & taken_o & ~is_ret_o;

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_done_lag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> ##2 done_o);

  assert_entry_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_done |-> (!status_o[STAT_T] && status_o[STAT_I]));

  assert_entry_save_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_done |-> (saved_o == $past(status_i, 2) && link_o == $past(pc_i, 2) + XLEN'(4)));

  assert_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_done |-> (pc_o == (($past(hivec_i, 2) ? HI_BASE : '0) + (XLEN'(code_o) << 2))));

  assert_irq_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_done && code_o == EX_IRQ) |-> !$past(status_i[STAT_I], 2));

  assert_fiq_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_done && code_o == EX_FIQ) |-> !$past(status_i[STAT_F], 2));

  assert_refused_ret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_ret_o && !taken_o) |-> (status_o == $past(status_i, 2) && pc_o == $past(pc_i, 2)));
endmodule

bind trap_sequencer trap_sequencer_chk #(.XLEN(XLEN), .HI_BASE(HI_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .status_i    (status_i),
  .pc_i        (pc_i),
  .hivec_i     (hivec_i),
  .done_o      (done_o),
  .taken_o     (taken_o),
  .is_ret_o    (is_ret_o),
  .code_o      (code_o),
  .status_o    (status_o),
  .pc_o        (pc_o),
  .saved_o     (saved_o),
  .link_o      (link_o)
);

// File: tb/sim_trap_sequencer.sv
module sim_trap_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_ret = 1'b0;
  logic [6:0]  pend = '0;
  logic [31:0] status = '0;
  logic [31:0] pc = '0;
  logic        hivec = 1'b0;
  logic        done, taken, is_ret;
  logic [2:0]  code;
  logic [31:0] status_q, pc_q, saved, link;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ret_i(req_ret), .pend_i(pend), .status_i(status), .pc_i(pc), .hivec_i(hivec),
    .done_o(done), .taken_o(taken), .is_ret_o(is_ret), .code_o(code),
    .status_o(status_q), .pc_o(pc_q), .saved_o(saved), .link_o(link)
  );

  typedef struct {
    logic        taken;
    logic        ret;
    logic [2:0]  code;
    logic [31:0] status;
    logic [31:0] pc;
    logic [31:0] saved;
    logic [31:0] link;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_stat [5];
  logic [31:0] m_link [5];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] fl, input bit i, input bit f,
                                     input bit t, input logic [4:0] m);
    return {fl, 20'h0, i, f, t, m};
  endfunction

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  // expected result from the requirements, updates the bank model
  function automatic exp_t model(input bit r, input logic [6:0] p, input logic [31:0] s,
                                 input logic [31:0] c, input bit hv, input string req);
    exp_t e;
    int   src = -1;
    int   b;
    logic [2:0] codes [7] = '{3'd0, 3'd4, 3'd7, 3'd6, 3'd3, 3'd1, 3'd2};
    logic [4:0] modes [7] = '{5'h13, 5'h17, 5'h11, 5'h12, 5'h17, 5'h1B, 5'h13};
    e.req = req; e.ret = r; e.taken = 1'b0; e.code = '0;
    e.status = s; e.pc = c; e.saved = '0; e.link = '0;
    if (r) begin
      b = bidx(s[4:0]);
      if (!s[5] && b >= 0) begin
        e.taken = 1'b1; e.status = m_stat[b]; e.pc = m_link[b];
      end
    end else begin
      for (int k = 6; k >= 0; k--) begin
        if (p[k] && !(k == 3 && s[7]) && !(k == 2 && s[6])) src = k;
      end
      if (src >= 0) begin
        e.taken  = 1'b1;
        e.code   = codes[src];
        e.status = s;
        e.status[4:0] = modes[src];
        e.status[5] = 1'b0;
        e.status[7] = 1'b1;
        if (src == 0 || src == 2) e.status[6] = 1'b1;
        e.pc    = (hv ? 32'hFFFF_0000 : 32'h0) + {27'h0, codes[src], 2'b00};
        e.saved = s;
        e.link  = c + 32'd4;
        b = bidx(modes[src]);
        m_stat[b] = s;
        m_link[b] = c + 32'd4;
      end
    end
    return e;
  endfunction

  task automatic do_op(input bit r, input logic [6:0] p, input logic [31:0] s,
                       input logic [31:0] c, input bit hv, input string req);
    sb.push_back(model(r, p, s, c, hv, req));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ret = r; pend = p; status = s; pc = c; hivec = hv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // scramble inputs: they must have been captured at acceptance
    pend = ~p; status = ~s; pc = ~c; hivec = ~hv; req_ret = ~r;
    check(!req_ready && !done, "R11", "busy after accept", {30'h0, req_ready, done}, 32'h0);
    @(negedge clk);
    check(done === 1'b1, "R11", "done two edges after accept", {31'h0, done}, 32'h1);
    @(negedge clk);
    check(done === 1'b0, "R11", "done single pulse", {31'h0, done}, 32'h0);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected result", 32'h0, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(taken === e.taken && is_ret === e.ret, e.req, "taken/is_ret",
              {30'h0, taken, is_ret}, {30'h0, e.taken, e.ret});
        check(code === e.code, e.req, "code", {29'h0, code}, {29'h0, e.code});
        check(status_q === e.status, e.req, "status", status_q, e.status);
        check(pc_q === e.pc, e.req, "pc", pc_q, e.pc);
        check(saved === e.saved, e.req, "saved", saved, e.saved);
        check(link === e.link, e.req, "link", link, e.link);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 5; b++) begin m_stat[b] = '0; m_link[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1 && done === 1'b0, "R1", "ready/done", {30'h0, req_ready, done}, 32'h2);
    check(status_q === '0 && pc_q === '0 && saved === '0 && link === '0 && taken === 1'b0,
          "R1", "results zero", status_q | pc_q | saved | link, 32'h0);

    // R2 R5 R6 R7: reset beats all, from user mode with flags
    do_op(0, 7'h7F, mk(4'hA, 0, 0, 1, 5'h10), 32'h0000_1000, 0, "R2");
    // R2: data abort next
    do_op(0, 7'h7E, mk(4'h5, 0, 0, 0, 5'h10), 32'h0000_2000, 0, "R2");
    // R2 R5: fast interrupt next
    do_op(0, 7'h7C, mk(4'h0, 0, 0, 0, 5'h10), 32'h0000_3000, 0, "R5");
    // R2: normal interrupt next, F preset kept
    do_op(0, 7'h78, mk(4'hF, 0, 1, 0, 5'h10), 32'h0000_4000, 0, "R6");
    // R3: both interrupts masked, prefetch abort wins
    do_op(0, 7'h1C, mk(4'h0, 1, 1, 0, 5'h1F), 32'h0000_5000, 0, "R3");
    // R3: fast masked, normal open
    do_op(0, 7'h0C, mk(4'h0, 0, 1, 0, 5'h10), 32'h0000_6000, 0, "R3");
    // R4: undefined beats software interrupt, high vectors
    do_op(0, 7'h60, mk(4'h3, 0, 0, 0, 5'h10), 32'h0000_7000, 1, "R4");
    // R4 R5: software interrupt alone, high vectors
    do_op(0, 7'h40, mk(4'h8, 0, 0, 1, 5'h10), 32'h0000_8000, 1, "R4");
    // R10: only masked sources pending
    do_op(0, 7'h0C, mk(4'h2, 1, 1, 0, 5'h10), 32'h0000_9000, 0, "R10");
    // R10: nothing pending
    do_op(0, 7'h00, mk(4'h0, 0, 0, 0, 5'h10), 32'h0000_A000, 1, "R10");
    // R8: return from supervisor and from fast interrupt mode
    do_op(1, 7'h7F, mk(4'h0, 1, 0, 0, 5'h13), 32'h0000_B000, 0, "R8");
    do_op(1, 7'h00, mk(4'h0, 1, 1, 0, 5'h11), 32'h0000_C000, 0, "R8");
    do_op(1, 7'h00, mk(4'h0, 1, 0, 0, 5'h17), 32'h0000_C100, 0, "R8");
    // R9: return refused in compact state and from user mode
    do_op(1, 7'h00, mk(4'h0, 1, 0, 1, 5'h12), 32'h0000_D000, 0, "R9");
    do_op(1, 7'h00, mk(4'h1, 0, 0, 0, 5'h10), 32'h0000_E000, 0, "R9");
    // R7: entry rebanks supervisor, return shows the new copy
    do_op(0, 7'h40, mk(4'h6, 0, 1, 0, 5'h1B), 32'h0000_F000, 0, "R7");
    do_op(1, 7'h00, mk(4'h0, 1, 0, 0, 5'h13), 32'h0001_0000, 0, "R7");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R11", "all results seen", sb.size(), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule